// File: doc/BRIEF.md
# Memory Fault Syndrome Generator

This block sits beside a processor's load/store and fetch pipeline and turns fault events into the values that exception software reads. Two event sources feed it: a strobe reporting a misaligned data access, and a strobe reporting the result of an address-translation lookup. From these it builds a 32-bit exception syndrome word and captures the faulting address in a separate register.

Every source raises its own request. A misaligned access raises a one-cycle hardware-exception request. A translation fault raises a memory-management exception request, which stays high until the core says it has taken the exception. A second translation fault that arrives while that request is still pending is flagged as a fatal recursive fault. A probe-only lookup that misses is reported back to the requester and changes no register.

Top module: `fault_syndrome_gen`

## Requirements
- R1: A cycle with `ua_valid` high and no translation fault writes the syndrome with cause `UA_CAUSE` (default 1) in bits 4:0 and copies `ua_addr` into `fault_addr`. In the cycle after the strobe, `hw_exc_req` is high for one cycle.
- R2: For a misaligned access, `ua_stat & STATUS_MASK` (default 0x00000FE0) is ORed into the syndrome only when `ua_stat_valid` is 1. Otherwise the syndrome holds only the cause code.
- R3: A translation fault is `xl_valid`=1, `xl_hit`=0 and `xl_probe`=0. Access kinds are encoded 0 = fetch, 1 = load, 2 = store, and 3 is treated as a load. A protection fault (`xl_miss`=0) gives cause 17 for a fetch and 16 for a data access.
- R4: A miss fault (`xl_miss`=1) gives cause 19 for a fetch and 18 for a data access.
- R5: Syndrome bit 10 is set by a translation fault only when its access kind is store. All other syndrome bits outside 4:0 are zero after a translation fault.
- R6: An accepted translation fault copies `xl_addr` into `fault_addr` and sets `mmu_exc_req` in the next cycle. `mmu_exc_req` stays high until a cycle with `mmu_taken` high and no new fault.
- R7: A translation fault arriving while `mmu_exc_req` is high and `mmu_taken` is low pulses `recursive_fault` for one cycle. It leaves the syndrome, `fault_addr` and `mmu_exc_req` unchanged. When `mmu_taken` and a new fault coincide, the new fault is accepted normally.
- R8: A probe lookup that misses (`xl_valid`, `xl_probe`, !`xl_hit`) pulses `probe_fail` for one cycle. It changes neither register and does not raise `mmu_exc_req`.
- R9: Reset clears every output to zero. A hit lookup, or a cycle with no strobe, leaves the syndrome and `fault_addr` unchanged.
- R10: When a translation fault and a misaligned access arrive in the same cycle, the translation fault wins. The misaligned access is dropped and `hw_exc_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ua_valid | input | 1 | Misaligned data access strobe |
| ua_addr | input | ADDR_W | Address of the misaligned access |
| ua_stat_valid | input | 1 | Instruction status bits are valid |
| ua_stat | input | 32 | Instruction-specific status bits |
| xl_valid | input | 1 | Translation result strobe |
| xl_hit | input | 1 | Lookup hit |
| xl_miss | input | 1 | Error kind: 1 miss, 0 protection |
| xl_kind | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| xl_probe | input | 1 | Lookup is a probe only |
| xl_addr | input | ADDR_W | Virtual address of the lookup |
| mmu_taken | input | 1 | Core has taken the MMU exception |
| syndrome | output | 32 | Exception syndrome value |
| fault_addr | output | ADDR_W | Exception address value |
| hw_exc_req | output | 1 | Hardware exception request pulse |
| mmu_exc_req | output | 1 | Pending MMU exception request |
| recursive_fault | output | 1 | Fatal recursive translation fault pulse |
| probe_fail | output | 1 | Probe lookup missed |

## Verification
The only internal state is the two data registers and the pending flag, so any corruption shows at the ports one cycle after the event that caused it. A wrong pending flag appears right away as a wrong `mmu_exc_req`. It also appears one cycle after the next translation fault, either as a missing `recursive_fault` pulse or as a syndrome overwritten when it should have been kept. A wrong cause or store bit appears in the syndrome in the cycle after the fault, and the bench reference compares every output on every clock.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  localparam int SYN_W   = 32;
  localparam int CAUSE_W = 5;
  localparam int STORE_BIT = 10;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  // cause code for a translation fault: protection 16/17, miss 18/19
  function automatic logic [CAUSE_W-1:0] xlat_cause(input logic miss,
                                                    input acc_kind_e kind);
    logic [CAUSE_W-1:0] c;
    unique case ({miss, kind == ACC_FETCH})
      2'b00:   c = CAUSE_W'(16);
      2'b01:   c = CAUSE_W'(17);
      2'b10:   c = CAUSE_W'(18);
      default: c = CAUSE_W'(19);
    endcase
    return c;
  endfunction

  function automatic logic [SYN_W-1:0] xlat_syndrome(input logic miss,
                                                     input acc_kind_e kind);
    logic [SYN_W-1:0] s;
    s = '0;
    s[CAUSE_W-1:0] = xlat_cause(miss, kind);
    s[STORE_BIT]   = (kind == ACC_STORE);
    return s;
  endfunction
endpackage

// File: rtl/fsg_xlat_decode.sv
module fsg_xlat_decode
  import fsg_pkg::*;
(
  input  logic             xl_valid,
  input  logic             xl_hit,
  input  logic             xl_miss,
  input  logic [1:0]       xl_kind,
  input  logic             xl_probe,
  output logic             fault,
  output logic             probe_miss,
  output logic [SYN_W-1:0] fault_syn
);
  logic lookup_missed;
  acc_kind_e kind;

  assign kind          = acc_kind_e'(xl_kind);
  assign lookup_missed = xl_valid && !xl_hit;
  assign fault         = lookup_missed && !xl_probe;
  assign probe_miss    = lookup_missed && xl_probe;

  always_comb begin
    fault_syn = xlat_syndrome(xl_miss, kind);
  end
endmodule

// File: rtl/fsg_ua_decode.sv
module fsg_ua_decode
  import fsg_pkg::*;
#(
  parameter int unsigned          UA_CAUSE    = 1,
  parameter logic [SYN_W-1:0]     STATUS_MASK = 32'h0000_0FE0
) (
  input  logic             stat_valid,
  input  logic [SYN_W-1:0] stat,
  output logic [SYN_W-1:0] ua_syn
);
  logic [SYN_W-1:0] merged;

  // per-bit status merge, only where the mask allows it
  for (genvar b = 0; b < SYN_W; b++) begin : g_bit
    if (STATUS_MASK[b]) begin : g_keep
      assign merged[b] = stat_valid & stat[b];
    end else begin : g_drop
      assign merged[b] = 1'b0;
    end
  end

  assign ua_syn = merged | SYN_W'(UA_CAUSE);
endmodule

// File: rtl/fsg_regs.sv
module fsg_regs
  import fsg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfault,
  input  logic              pmiss,
  input  logic [SYN_W-1:0]  xsyn,
  input  logic [ADDR_W-1:0] xaddr,
  input  logic              ua_valid,
  input  logic [SYN_W-1:0]  usyn,
  input  logic [ADDR_W-1:0] uaddr,
  input  logic              mmu_taken,
  output logic              xaccept,
  output logic              ua_take,
  output logic [SYN_W-1:0]  syn_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              hw_q,
  output logic              pend_q,
  output logic              rec_q,
  output logic              pf_q
);
  logic recursive;

  assign xaccept   = xfault && (!pend_q || mmu_taken);
  assign recursive = xfault && pend_q && !mmu_taken;
  assign ua_take   = ua_valid && !xfault;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      syn_q  <= '0;
      addr_q <= '0;
      hw_q   <= 1'b0;
      pend_q <= 1'b0;
      rec_q  <= 1'b0;
      pf_q   <= 1'b0;
    end else begin
      hw_q  <= ua_take;
      rec_q <= recursive;
      pf_q  <= pmiss;
      if (xaccept) begin
        syn_q  <= xsyn;
        addr_q <= xaddr;
        pend_q <= 1'b1;
      end else begin
        if (mmu_taken) pend_q <= 1'b0;
        if (ua_take) begin
          syn_q  <= usyn;
          addr_q <= uaddr;
        end
      end
    end
  end
endmodule

// File: rtl/fault_syndrome_gen.sv
module fault_syndrome_gen
  import fsg_pkg::*;
#(
  parameter int               ADDR_W      = 32,
  parameter int unsigned      UA_CAUSE    = 1,
  parameter logic [31:0]      STATUS_MASK = 32'h0000_0FE0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ua_valid,
  input  logic [ADDR_W-1:0] ua_addr,
  input  logic              ua_stat_valid,
  input  logic [31:0]       ua_stat,
  input  logic              xl_valid,
  input  logic              xl_hit,
  input  logic              xl_miss,
  input  logic [1:0]        xl_kind,
  input  logic              xl_probe,
  input  logic [ADDR_W-1:0] xl_addr,
  input  logic              mmu_taken,
  output logic [31:0]       syndrome,
  output logic [ADDR_W-1:0] fault_addr,
  output logic              hw_exc_req,
  output logic              mmu_exc_req,
  output logic              recursive_fault,
  output logic              probe_fail
);
  logic             xlat_fault;
  logic             xlat_probe_miss;
  logic             xlat_accept;
  logic             ua_take;
  logic [SYN_W-1:0] xlat_syn;
  logic [SYN_W-1:0] ua_syn;

  fsg_xlat_decode u_xlat (
    .xl_valid   (xl_valid),
    .xl_hit     (xl_hit),
    .xl_miss    (xl_miss),
    .xl_kind    (xl_kind),
    .xl_probe   (xl_probe),
    .fault      (xlat_fault),
    .probe_miss (xlat_probe_miss),
    .fault_syn  (xlat_syn)
  );

  fsg_ua_decode #(
    .UA_CAUSE    (UA_CAUSE),
    .STATUS_MASK (STATUS_MASK)
  ) u_ua (
    .stat_valid (ua_stat_valid),
    .stat       (ua_stat),
    .ua_syn     (ua_syn)
  );

  fsg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfault    (xlat_fault),
    .pmiss     (xlat_probe_miss),
    .xsyn      (xlat_syn),
    .xaddr     (xl_addr),
    .ua_valid  (ua_valid),
    .usyn      (ua_syn),
    .uaddr     (ua_addr),
    .mmu_taken (mmu_taken),
    .xaccept   (xlat_accept),
    .ua_take   (ua_take),
    .syn_q     (syndrome),
    .addr_q    (fault_addr),
    .hw_q      (hw_exc_req),
    .pend_q    (mmu_exc_req),
    .rec_q     (recursive_fault),
    .pf_q      (probe_fail)
  );
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ua_valid,
  input logic [ADDR_W-1:0] ua_addr,
  input logic              xl_kind_store,
  input logic [ADDR_W-1:0] xl_addr,
  input logic              mmu_taken,
  input logic              xlat_fault,
  input logic              xlat_accept,
  input logic              xlat_probe_miss,
  input logic              ua_take,
  input logic [31:0]       syndrome,
  input logic [ADDR_W-1:0] fault_addr,
  input logic              hw_exc_req,
  input logic              mmu_exc_req,
  input logic              recursive_fault,
  input logic              probe_fail
);
  p_ua_request_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ua_take |=> hw_exc_req && fault_addr == $past(ua_addr));

  p_cause_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_accept |=> syndrome[4:0] >= 5'd16 && syndrome[4:0] <= 5'd19);

  p_store_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_accept |=> syndrome[10] == $past(xl_kind_store));

  p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_accept |=> mmu_exc_req && fault_addr == $past(xl_addr));

  p_pending_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mmu_exc_req && !mmu_taken |=> mmu_exc_req);

  p_recursive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_fault && mmu_exc_req && !mmu_taken |=>
      recursive_fault && $stable(syndrome) && $stable(fault_addr));

  p_probe_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_probe_miss && !ua_valid |=>
      probe_fail && $stable(syndrome) && $stable(fault_addr));

  p_fault_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_fault && ua_valid |=> !hw_exc_req);
endmodule

bind fault_syndrome_gen fsg_checker #(.ADDR_W(ADDR_W)) u_fsg_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .ua_valid        (ua_valid),
  .ua_addr         (ua_addr),
  .xl_kind_store   (xl_kind == 2'd2),
  .xl_addr         (xl_addr),
  .mmu_taken       (mmu_taken),
  .xlat_fault      (xlat_fault),
  .xlat_accept     (xlat_accept),
  .xlat_probe_miss (xlat_probe_miss),
  .ua_take         (ua_take),
  .syndrome        (syndrome),
  .fault_addr      (fault_addr),
  .hw_exc_req      (hw_exc_req),
  .mmu_exc_req     (mmu_exc_req),
  .recursive_fault (recursive_fault),
  .probe_fail      (probe_fail)
);

// File: tb/tb_fault_syndrome_gen.sv
module tb_fault_syndrome_gen;
  localparam int CLK_PERIOD = 10;
  localparam int UA_CODE = 1;
  localparam logic [31:0] SMASK = 32'h0000_0FE0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ua_valid = 0, ua_stat_valid = 0, xl_valid = 0, xl_hit = 0;
  logic xl_miss = 0, xl_probe = 0, mmu_taken = 0;
  logic [1:0]  xl_kind = 0;
  logic [31:0] ua_addr = 0, ua_stat = 0, xl_addr = 0;
  logic [31:0] syndrome, fault_addr;
  logic hw_exc_req, mmu_exc_req, recursive_fault, probe_fail;

  int vectors = 0;
  int errors = 0;

  // reference state
  logic [31:0] m_syn = 0, m_addr = 0;
  logic m_hw = 0, m_pend = 0, m_rec = 0, m_pf = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_syndrome_gen dut (
    .clk(clk), .rst_n(rst_n),
    .ua_valid(ua_valid), .ua_addr(ua_addr),
    .ua_stat_valid(ua_stat_valid), .ua_stat(ua_stat),
    .xl_valid(xl_valid), .xl_hit(xl_hit), .xl_miss(xl_miss),
    .xl_kind(xl_kind), .xl_probe(xl_probe), .xl_addr(xl_addr),
    .mmu_taken(mmu_taken),
    .syndrome(syndrome), .fault_addr(fault_addr),
    .hw_exc_req(hw_exc_req), .mmu_exc_req(mmu_exc_req),
    .recursive_fault(recursive_fault), .probe_fail(probe_fail)
  );

  task automatic compare(input string tag);
    vectors++;
    if (syndrome !== m_syn || fault_addr !== m_addr || hw_exc_req !== m_hw ||
        mmu_exc_req !== m_pend || recursive_fault !== m_rec || probe_fail !== m_pf) begin
      errors++;
      $display("FAIL %s: got syn=%h addr=%h hw=%b mmu=%b rec=%b pf=%b exp syn=%h addr=%h hw=%b mmu=%b rec=%b pf=%b",
               tag, syndrome, fault_addr, hw_exc_req, mmu_exc_req, recursive_fault, probe_fail,
               m_syn, m_addr, m_hw, m_pend, m_rec, m_pf);
    end
  endtask

  // drive one cycle of stimulus, advance the model, compare after the edge
  task automatic step(input logic uv, input logic [31:0] ua, input logic sv,
                      input logic [31:0] st, input logic xv, input logic xh,
                      input logic xm, input logic [1:0] xk, input logic xp,
                      input logic [31:0] xa, input logic tk, input string tag);
    int code;
    bit fault, pmiss;
    ua_valid = uv; ua_addr = ua; ua_stat_valid = sv; ua_stat = st;
    xl_valid = xv; xl_hit = xh; xl_miss = xm; xl_kind = xk; xl_probe = xp;
    xl_addr = xa; mmu_taken = tk;
    fault = xv && !xh && !xp;
    pmiss = xv && !xh && xp;
    m_hw = 0; m_rec = 0; m_pf = pmiss;
    if (fault) begin
      if (m_pend && !tk) m_rec = 1;
      else begin
        code = 16;
        if (xm) code += 2;
        if (xk == 2'd0) code += 1;
        if (xk == 2'd2) code += 1024;
        m_syn = code;
        m_addr = xa;
        m_pend = 1;
      end
    end else begin
      if (tk) m_pend = 0;
      if (uv) begin
        m_syn = UA_CODE;
        if (sv) m_syn = m_syn | (st & SMASK);
        m_addr = ua;
        m_hw = 1;
      end
    end
    @(posedge clk);
    #1;
    compare(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    compare("R9 reset");
    rst_n = 1'b1;
    idle("R9 idle after reset");

    // R1 / R2 misaligned
    step(1, 32'h1000_0003, 0, 32'hFFFF_FFFF, 0,0,0,0,0,0, 0, "R1 ua no status");
    idle("R1 pulse ends");
    step(1, 32'h2000_0001, 1, 32'hFFFF_FFFF, 0,0,0,0,0,0, 0, "R2 ua status masked");
    step(1, 32'h2000_0002, 1, 32'h0000_0120, 0,0,0,0,0,0, 0, "R2 ua status partial");

    // R3 protection, R5 store bit, R6 pending
    step(0,0,0,0, 1,0,0,2'd0,0, 32'hA000_0010, 0, "R3 prot fetch");
    idle("R6 pending holds");
    step(0,0,0,0, 0,0,0,0,0,0, 1, "R6 taken clears");
    step(0,0,0,0, 1,0,0,2'd1,0, 32'hA000_0020, 0, "R3 prot load");
    step(0,0,0,0, 0,0,0,0,0,0, 1, "R6 taken");
    step(0,0,0,0, 1,0,0,2'd2,0, 32'hA000_0030, 0, "R5 prot store");
    step(0,0,0,0, 0,0,0,0,0,0, 1, "R6 taken");

    // R4 miss
    step(0,0,0,0, 1,0,1,2'd0,0, 32'hB000_0000, 0, "R4 miss fetch");
    step(0,0,0,0, 0,0,0,0,0,0, 1, "R6 taken");
    step(0,0,0,0, 1,0,1,2'd1,0, 32'hB000_1000, 0, "R4 miss load");
    // R7 recursive while pending
    step(0,0,0,0, 1,0,1,2'd2,0, 32'hC000_0000, 0, "R7 recursive");
    idle("R7 pulse ends");
    // R7 taken coincides with new fault: accepted
    step(0,0,0,0, 1,0,1,2'd2,0, 32'hC000_0004, 1, "R7 taken with new fault");
    step(0,0,0,0, 1,0,0,2'd3,0, 32'hC000_0008, 1, "R3 reserved kind as load");
    step(0,0,0,0, 0,0,0,0,0,0, 1, "R6 taken");

    // R8 probe miss, R9 hits
    step(0,0,0,0, 1,0,1,2'd1,1, 32'hD000_0000, 0, "R8 probe miss");
    step(0,0,0,0, 1,1,0,2'd2,1, 32'hD000_0004, 0, "R9 probe hit");
    step(0,0,0,0, 1,1,1,2'd2,0, 32'hD000_0008, 0, "R9 hit ignored");
    idle("R9 hold");

    // R10 simultaneous
    step(1, 32'hE000_0001, 1, 32'hFFF, 1,0,0,2'd1,0, 32'hE000_1000, 0, "R10 fault beats ua");
    step(1, 32'hE000_0003, 0, 0, 0,0,0,0,0,0, 1, "R1 ua while taken");

    // random traffic
    for (int i = 0; i < 400; i++) begin
      step($urandom_range(0,1), $urandom, $urandom_range(0,1), $urandom,
           $urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1),
           2'($urandom_range(0,3)), $urandom_range(0,1), $urandom,
           $urandom_range(0,3) == 0, "R7 R10 random mix");
    end

    rst_n = 1'b0;
    m_syn = 0; m_addr = 0; m_hw = 0; m_pend = 0; m_rec = 0; m_pf = 0;
    @(posedge clk);
    #1;
    compare("R9 second reset");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule